// File: doc/BRIEF.md
# Oversampling Pulse Catcher

This block catches very short asynchronous pulses on several independent lines and reports each one as a single-cycle event in the system clock domain. A fast sampling clock, eight times the system rate, samples every line through a short register chain. A rising edge on the settled samples is registered as a detection. The detection is then carried across the clock boundary by a toggle request/acknowledge handshake, which produces exactly one system-domain strobe per pulse.

A pulse is treated as lost if its rising edge arrives while the previous detection on the same line is still waiting for the system domain to acknowledge it. A lost pulse raises a sticky per-line flag, which is also brought into the system domain. The flag stays set until reset. Both clocks come from outside the block. The strobes have no back-pressure: the consumer must take each one in the cycle it is asserted. The design assumes pulses at least about 1.4 fast-clock periods wide, so that every pulse is sampled high at least once.

Top module: `pulse_catcher`

## Requirements
- R1: While reset is asserted and right after its release, every `event_o` bit and every `missed_o` bit is 0.
- R2: A pulse of 1.4 to 3.4 fast-clock periods, at any phase relative to either clock, produces exactly one `event_o` strobe on its own line within 8 system cycles of its start.
- R3: Every `event_o` strobe is high for exactly one system cycle.
- R4: A line held high for many fast-clock periods is reported once.
- R5: Lines are independent. A pulse on one line produces no strobe on any other line, and simultaneous pulses on all lines produce one strobe each.
- R6: If a rising edge arrives while the previous detection on the same line is still unacknowledged, no extra strobe is produced and that line's `missed_o` bit goes to 1 within 8 system cycles.
- R7: A set `missed_o` bit stays at 1 until reset, including through later correctly reported pulses, and it does not affect the other lines' bits.
- R8: Pulses on one line spaced at least 8 system cycles apart are each reported, and `missed_o` stays 0.
- R9: A new request is handed to the system domain only when the previous request on that line has been acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Sampling clock, eight times the system rate |
| clk_sys | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| pulse_in | input | CHANNELS | Raw asynchronous pulse lines |
| event_o | output | CHANNELS | One-cycle strobe per caught pulse, system domain |
| missed_o | output | CHANNELS | Sticky lost-pulse flag per line, system domain |

## Verification
Single pulses are swept over every line, all eight fast-clock phases inside a system period, and three widths. This separates a correct edge detector from one that misses narrow pulses or double-counts wide ones. A long held level tests the edge-only rule, and pulses on all lines at once test independence. A closely spaced pair on one line tests the busy path: it must give one strobe plus a sticky flag and leave the neighbours clean. A following pulse and a reset show that the flag persists and then clears.

// File: rtl/pulse_catcher_pkg.sv
`timescale 1ps/1ps
package pulse_catcher_pkg;
  localparam int MIN_SAMPLE_STAGES = 3;
  localparam int MIN_SYNC_STAGES   = 2;

  // newest settled sample high, the one before it low
  function automatic logic is_rise(input logic cur, input logic prv);
    return cur & ~prv;
  endfunction

  // toggle handshake: request outstanding while the two sides differ
  function automatic logic pending(input logic req, input logic ack);
    return req ^ ack;
  endfunction
endpackage

// File: rtl/pc_sync.sv
`timescale 1ps/1ps
module pc_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pc_fast_lane.sv
`timescale 1ps/1ps
module pc_fast_lane
  import pulse_catcher_pkg::*;
#(
  parameter int SAMPLE_STAGES = 3,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk_fast,
  input  logic rst_n,
  input  logic pulse_raw,
  input  logic ack_tgl,   // from system domain
  output logic req_tgl,
  output logic ack_seen,
  output logic missed
);
  localparam int CUR = SAMPLE_STAGES - 2;
  localparam int PRV = SAMPLE_STAGES - 1;

  logic [SAMPLE_STAGES-1:0] samp;
  logic hit_q, req_q, miss_q, ack_f, busy;

  pc_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_ack_sync (
    .clk(clk_fast), .rst_n(rst_n), .d(ack_tgl), .q(ack_f)
  );

  // sample chain, bit 0 newest
  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) samp <= '0;
    else        samp <= {samp[SAMPLE_STAGES-2:0], pulse_raw};
  end

  // detection latch
  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= is_rise(samp[CUR], samp[PRV]);
  end

  assign busy = pending(req_q, ack_f);

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      miss_q <= 1'b0;
    end else if (hit_q) begin
      if (busy) miss_q <= 1'b1;
      else      req_q  <= ~req_q;
    end
  end

  assign req_tgl  = req_q;
  assign ack_seen = ack_f;
  assign missed   = miss_q;
endmodule

// File: rtl/pc_sys_lane.sv
`timescale 1ps/1ps
module pc_sys_lane #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_sys,
  input  logic rst_n,
  input  logic req_tgl,     // from fast domain
  input  logic missed_raw,  // from fast domain, sticky level
  output logic ack_tgl,
  output logic strobe,
  output logic missed
);
  logic req_s, prev_q, evt_q;

  pc_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_req_sync (
    .clk(clk_sys), .rst_n(rst_n), .d(req_tgl), .q(req_s)
  );
  pc_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_miss_sync (
    .clk(clk_sys), .rst_n(rst_n), .d(missed_raw), .q(missed)
  );

  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      prev_q <= req_s;
      evt_q  <= req_s ^ prev_q;
    end
  end

  assign ack_tgl = prev_q;
  assign strobe  = evt_q;
endmodule

// File: rtl/pulse_catcher.sv
`timescale 1ps/1ps
module pulse_catcher
  import pulse_catcher_pkg::*;
#(
  parameter int CHANNELS      = 8,
  parameter int SAMPLE_STAGES = MIN_SAMPLE_STAGES,
  parameter int SYNC_STAGES   = MIN_SYNC_STAGES
) (
  input  logic                clk_fast,
  input  logic                clk_sys,
  input  logic                rst_n,
  input  logic [CHANNELS-1:0] pulse_in,
  output logic [CHANNELS-1:0] event_o,
  output logic [CHANNELS-1:0] missed_o
);
  logic [CHANNELS-1:0] req_vec, ack_vec, ack_seen_vec, miss_fast_vec;

  for (genvar c = 0; c < CHANNELS; c++) begin : g_lane
    pc_fast_lane #(.SAMPLE_STAGES(SAMPLE_STAGES), .SYNC_STAGES(SYNC_STAGES)) u_fast (
      .clk_fast (clk_fast),
      .rst_n    (rst_n),
      .pulse_raw(pulse_in[c]),
      .ack_tgl  (ack_vec[c]),
      .req_tgl  (req_vec[c]),
      .ack_seen (ack_seen_vec[c]),
      .missed   (miss_fast_vec[c])
    );
    pc_sys_lane #(.SYNC_STAGES(SYNC_STAGES)) u_sys (
      .clk_sys   (clk_sys),
      .rst_n     (rst_n),
      .req_tgl   (req_vec[c]),
      .missed_raw(miss_fast_vec[c]),
      .ack_tgl   (ack_vec[c]),
      .strobe    (event_o[c]),
      .missed    (missed_o[c])
    );
  end
endmodule

// File: rtl/pulse_catcher_sva.sv
`timescale 1ps/1ps
module pulse_catcher_sva #(
  parameter int CHANNELS = 8
) (
  input logic                clk_fast,
  input logic                clk_sys,
  input logic                rst_n,
  input logic [CHANNELS-1:0] event_o,
  input logic [CHANNELS-1:0] missed_o,
  input logic [CHANNELS-1:0] req_vec,
  input logic [CHANNELS-1:0] ack_vec,
  input logic [CHANNELS-1:0] ack_seen_vec,
  input logic [CHANNELS-1:0] miss_fast_vec
);
  for (genvar c = 0; c < CHANNELS; c++) begin : g_chk
    assert_strobe_one_cycle_R3: assert property (@(posedge clk_sys) disable iff (!rst_n)
      event_o[c] |=> !event_o[c]);
    assert_strobe_with_ack_R2: assert property (@(posedge clk_sys) disable iff (!rst_n)
      event_o[c] |-> !$stable(ack_vec[c]));
    assert_missed_sticky_R7: assert property (@(posedge clk_sys) disable iff (!rst_n)
      missed_o[c] |=> missed_o[c]);
    assert_fast_miss_sticky_R6: assert property (@(posedge clk_fast) disable iff (!rst_n)
      miss_fast_vec[c] |=> miss_fast_vec[c]);
    assert_handover_idle_R9: assert property (@(posedge clk_fast) disable iff (!rst_n)
      !$stable(req_vec[c]) |-> $past(req_vec[c] == ack_seen_vec[c]));
  end
endmodule

bind pulse_catcher pulse_catcher_sva #(.CHANNELS(CHANNELS)) u_sva (
  .clk_fast     (clk_fast),
  .clk_sys      (clk_sys),
  .rst_n        (rst_n),
  .event_o      (event_o),
  .missed_o     (missed_o),
  .req_vec      (req_vec),
  .ack_vec      (ack_vec),
  .ack_seen_vec (ack_seen_vec),
  .miss_fast_vec(miss_fast_vec)
);

// File: tb/pulse_catcher_bench.sv
`timescale 1ps/1ps
module pulse_catcher_bench;
  localparam int CH = 4;

  logic          clk_fast = 1'b0;
  logic          clk_sys  = 1'b0;
  logic          rst_n    = 1'b0;
  logic [CH-1:0] pulse_in = '0;
  logic [CH-1:0] event_o, missed_o;

  int tests = 0;
  int fails = 0;
  int ev_cnt [CH];
  int snap   [CH];
  bit prev_ev[CH];
  int dbl = 0;

  always #500  clk_fast = ~clk_fast;   // 1 GHz sampling
  always #4000 clk_sys  = ~clk_sys;    // 125 MHz system

  pulse_catcher #(.CHANNELS(CH)) u_pulse_catcher (
    .clk_fast(clk_fast), .clk_sys(clk_sys), .rst_n(rst_n),
    .pulse_in(pulse_in), .event_o(event_o), .missed_o(missed_o)
  );

  initial for (int c = 0; c < CH; c++) begin ev_cnt[c] = 0; prev_ev[c] = 0; end

  always @(negedge clk_sys) begin
    for (int c = 0; c < CH; c++) begin
      if (event_o[c] === 1'b1) begin
        ev_cnt[c]++;
        if (prev_ev[c]) dbl++;
      end
      prev_ev[c] = (event_o[c] === 1'b1);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic take_snap();
    for (int c = 0; c < CH; c++) snap[c] = ev_cnt[c];
  endtask

  task automatic wait_sys(input int n);
    repeat (n) @(posedge clk_sys);
    #1000;
  endtask

  task automatic check_delta(input logic [CH-1:0] hot, input string req);
    for (int c = 0; c < CH; c++)
      chk(ev_cnt[c] == snap[c] + int'(hot[c]), req, ev_cnt[c], snap[c] + int'(hot[c]));
  endtask

  task automatic fire(input int ch, input int width_ps);
    pulse_in[ch] = 1'b1;
    #(width_ps);
    pulse_in[ch] = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk_sys);
    #1000;
    chk(event_o == '0, "R1 event in reset", int'(event_o), 0);
    chk(missed_o == '0, "R1 missed in reset", int'(missed_o), 0);
    rst_n = 1'b1;
    wait_sys(2);
    chk(event_o == '0, "R1 event after reset", int'(event_o), 0);
    chk(missed_o == '0, "R1 missed after reset", int'(missed_o), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_sys);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();

    // R2 / R5 / R8: sweep line x phase x width, spacing above 8 system cycles
    for (int ch = 0; ch < CH; ch++)
      for (int k = 0; k < 8; k++)
        for (int wi = 0; wi < 3; wi++) begin
          take_snap();
          @(posedge clk_sys);
          #(k * 1000 + 200);
          fire(ch, 1400 + wi * 1000);
          wait_sys(8);
          check_delta(CH'(1) << ch, "R2 single pulse / R5 isolation");
        end
    chk(missed_o == '0, "R8 no loss on spaced pulses", int'(missed_o), 0);

    // R4: long level counted once
    take_snap();
    @(posedge clk_sys); #200;
    fire(1, 60000);
    wait_sys(8);
    check_delta(CH'(2), "R4 long level");

    // R5: all lines together
    take_snap();
    @(posedge clk_sys); #3200;
    pulse_in = '1; #2100; pulse_in = '0;
    wait_sys(8);
    check_delta('1, "R5 simultaneous");

    // R6: second edge while first is pending
    take_snap();
    @(posedge clk_sys); #200;
    fire(2, 2100);
    #3900;
    fire(2, 2100);
    wait_sys(8);
    check_delta(CH'(4), "R6 busy pulse dropped");
    chk(missed_o == CH'(4), "R6 missed flag on own line", int'(missed_o), 4);

    // R7: flag survives a later good pulse
    take_snap();
    @(posedge clk_sys); #1200;
    fire(2, 2400);
    wait_sys(8);
    check_delta(CH'(4), "R7 pulse after loss");
    chk(missed_o == CH'(4), "R7 missed sticky", int'(missed_o), 4);

    // R7 / R1: reset clears, then normal again
    do_reset();
    take_snap();
    @(posedge clk_sys); #5200;
    fire(2, 1400);
    wait_sys(8);
    check_delta(CH'(4), "R7 pulse after reset");
    chk(missed_o == '0, "R7 flag cleared by reset", int'(missed_o), 0);

    chk(dbl == 0, "R3 strobe one cycle", dbl, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule